// File: doc/BRIEF.md
# Six-Mode Barrel Shift and Rotate Unit

This block shifts or rotates an N-bit word by a signed distance in one pass through a log2(N)-stage barrel network. A 3-bit operation code picks one of six moves: logical shift left or right, arithmetic shift left or right, and rotate left or right. The two remaining codes pass the word through untouched. A negative distance swaps each operation for its mirror in the other direction, using the magnitude of the distance.

The arithmetic moves differ in how they fill vacated bits. An arithmetic right shift fills with copies of the top bit. An arithmetic left shift fills with copies of the bottom bit. Rotations take the distance modulo N. Shifts by N or more positions leave nothing but fill bits. A parameter places an output register after the network (the default). When it is cleared, the unit is purely combinational.

Top module: `shf_unit`

## Requirements
- R1: Opcode 000 shifts left and opcode 001 shifts right. Both fill vacated bits with 0, and a magnitude of N or more yields all zeros.
- R2: Opcode 010 shifts left and fills vacated bits with the original bit 0. A distance of N or more yields N copies of bit 0.
- R3: Opcode 011 shifts right and fills vacated bits with the original bit N-1. A distance of N or more yields N copies of bit N-1.
- R4: Opcode 100 rotates left and opcode 101 rotates right, both by the distance modulo N. No bit is lost or created.
- R5: A negative distance performs the opcode with bit 0 inverted (000↔001, 010↔011, 100↔101), by the absolute value of the distance.
- R6: For a 4-bit word 1100, the results are: op 000 by 1 gives 1000, op 001 by 2 gives 0011, op 010 by 1 gives 1000, op 011 by 2 gives 1111, op 100 by 1 gives 1001, op 101 by 2 gives 0011, and op 101 by -1 gives 1001.
- R7: A distance of zero returns the input word for every opcode.
- R8: Opcodes 110 and 111 return the input word for any distance.
- R9: With the output register enabled, a result appears one clock after its inputs are presented. An active-low asynchronous reset forces the output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| data_i | input | N | Word to shift or rotate |
| op_i | input | 3 | Operation code |
| cnt_i | input | clog2(N)+2 | Signed two's-complement distance |
| data_o | output | N | Shifted or rotated word |

## Verification
With the register enabled, every result is due exactly one rising edge after its inputs. The bench drives a vector on a falling edge, lets one rising edge pass, and samples on the next falling edge. At that point only the vector just applied can show at the output. The checker aligns with the same one-cycle delay: it keeps its own registered copy of the inputs and compares the output with that copy. Reset clearing is checked while reset is held, before any vector is applied.

// File: rtl/shf_pkg.sv
package shf_pkg;

   typedef enum logic [2:0] {
      OP_SLL  = 3'b000,
      OP_SRL  = 3'b001,
      OP_SLA  = 3'b010,
      OP_SRA  = 3'b011,
      OP_ROL  = 3'b100,
      OP_ROR  = 3'b101,
      OP_PASA = 3'b110,
      OP_PASB = 3'b111
   } shf_op_e;

   typedef enum logic [1:0] {
      FILL_ZERO = 2'd0,
      FILL_LSB  = 2'd1,
      FILL_MSB  = 2'd2
   } shf_fill_e;

   typedef struct packed {
      logic      go_left;
      logic      rotate;
      logic      pass;
      logic      saturate;
      shf_fill_e fill;
   } shf_ctrl_t;

endpackage

// File: rtl/shf_decode.sv
module shf_decode
   import shf_pkg::*;
#(
   parameter int N  = 32,
   localparam int SW = $clog2(N),
   localparam int CW = SW + 2
) (
   input  logic [2:0]    op_i,
   input  logic [CW-1:0] cnt_i,
   output shf_ctrl_t     ctrl_o,
   output logic [SW-1:0] amt_o
);

   localparam logic [CW-1:0] N_C = CW'(N);

   logic          neg;
   logic [CW-1:0] mag;
   logic [2:0]    eff;

   always_comb begin
      neg = cnt_i[CW-1];
      mag = neg ? (~cnt_i + 1'b1) : cnt_i;
      // a negative distance selects the mirror operation
      eff = (neg && op_i[2:1] != 2'b11) ? {op_i[2:1], ~op_i[0]} : op_i;

      ctrl_o.rotate   = (eff == OP_ROL) || (eff == OP_ROR);
      ctrl_o.go_left  = (eff == OP_SLL) || (eff == OP_SLA) || (eff == OP_ROL);
      ctrl_o.pass     = (op_i[2:1] == 2'b11) || (mag == '0);
      ctrl_o.saturate = !ctrl_o.rotate && (mag >= N_C);
      unique case (eff)
         OP_SLA:  ctrl_o.fill = FILL_LSB;
         OP_SRA:  ctrl_o.fill = FILL_MSB;
         default: ctrl_o.fill = FILL_ZERO;
      endcase
      amt_o = mag[SW-1:0];
   end

endmodule

// File: rtl/shf_stage.sv
module shf_stage #(
   parameter int N = 32,
   parameter int S = 1
) (
   input  logic [N-1:0] d_i,
   input  logic         en_i,
   input  logic         rot_i,
   input  logic         fill_i,
   output logic [N-1:0] q_o
);

   logic [N-1:0] moved;

   for (genvar i = 0; i < N; i++) begin : g_bit
      if (i + S < N) begin : g_in
         assign moved[i] = d_i[i+S];
      end else begin : g_wrap
         assign moved[i] = rot_i ? d_i[i+S-N] : fill_i;
      end
   end

   assign q_o = en_i ? moved : d_i;

endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
   parameter int N  = 32,
   localparam int SW = $clog2(N)
) (
   input  logic [N-1:0]  d_i,
   input  logic [SW-1:0] amt_i,
   input  logic          rot_i,
   input  logic          fill_i,
   output logic [N-1:0]  q_o
);

   logic [N-1:0] lvl [SW+1];

   assign lvl[0] = d_i;

   for (genvar k = 0; k < SW; k++) begin : g_stage
      shf_stage #(.N(N), .S(1 << k)) u_stage (
         .d_i    (lvl[k]),
         .en_i   (amt_i[k]),
         .rot_i  (rot_i),
         .fill_i (fill_i),
         .q_o    (lvl[k+1])
      );
   end

   assign q_o = lvl[SW];

endmodule

// File: rtl/shf_unit.sv
module shf_unit
   import shf_pkg::*;
#(
   parameter int  N       = 32,
   parameter bit  REG_OUT = 1'b1,
   localparam int SW      = $clog2(N),
   localparam int CW      = SW + 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  data_i,
   input  logic [2:0]    op_i,
   input  logic [CW-1:0] cnt_i,
   output logic [N-1:0]  data_o
);

   if (N < 2 || (N & (N - 1)) != 0) begin : g_bad_n
      $error("shf_unit: N must be a power of two of at least 2");
   end

   shf_ctrl_t     ctrl;
   logic [SW-1:0] amt;
   logic          fill_bit;
   logic [N-1:0]  flipped_in, barrel_out, flipped_out, result;

   shf_decode #(.N(N)) u_decode (
      .op_i   (op_i),
      .cnt_i  (cnt_i),
      .ctrl_o (ctrl),
      .amt_o  (amt)
   );

   always_comb begin
      unique case (ctrl.fill)
         FILL_LSB: fill_bit = data_i[0];
         FILL_MSB: fill_bit = data_i[N-1];
         default:  fill_bit = 1'b0;
      endcase
   end

   // left moves run through the right-moving network on a bit-reversed word
   for (genvar i = 0; i < N; i++) begin : g_rev
      assign flipped_in[i]  = ctrl.go_left ? data_i[N-1-i] : data_i[i];
      assign flipped_out[i] = ctrl.go_left ? barrel_out[N-1-i] : barrel_out[i];
   end

   shf_barrel #(.N(N)) u_barrel (
      .d_i    (flipped_in),
      .amt_i  (amt),
      .rot_i  (ctrl.rotate),
      .fill_i (fill_bit),
      .q_o    (barrel_out)
   );

   always_comb begin
      if (ctrl.pass)          result = data_i;
      else if (ctrl.saturate) result = {N{fill_bit}};
      else                    result = flipped_out;
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) data_o <= '0;
         else        data_o <= result;
      end
   end else begin : g_comb
      assign data_o = result;
   end

endmodule

// File: rtl/shf_unit_chk.sv
module shf_unit_chk #(
   parameter int  N       = 32,
   parameter bit  REG_OUT = 1'b1,
   localparam int SW      = $clog2(N),
   localparam int CW      = SW + 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic [N-1:0]  data_i,
   input logic [2:0]    op_i,
   input logic [CW-1:0] cnt_i,
   input logic [N-1:0]  data_o
);

   logic [N-1:0]  d_ref;
   logic [2:0]    op_ref;
   logic [CW-1:0] c_ref;
   logic          seen;
   int            sc;

   if (REG_OUT) begin : g_lag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            d_ref  <= '0;
            op_ref <= '0;
            c_ref  <= '0;
            seen   <= 1'b0;
         end else begin
            d_ref  <= data_i;
            op_ref <= op_i;
            c_ref  <= cnt_i;
            seen   <= 1'b1;
         end
      end
   end else begin : g_now
      assign d_ref  = data_i;
      assign op_ref = op_i;
      assign c_ref  = cnt_i;
      assign seen   = 1'b1;
   end

   assign sc = int'($signed(c_ref));

   a_r7_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && c_ref == '0) |-> (data_o == d_ref));

   a_r8_pass_codes: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && op_ref[2:1] == 2'b11) |-> (data_o == d_ref));

   a_r1_logic_sat: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && op_ref[2:1] == 2'b00 && (sc >= N || sc <= -N)) |-> (data_o == '0));

   a_r2_sla_sat: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && op_ref == 3'b010 && sc >= N) |-> (data_o == {N{d_ref[0]}}));

   a_r3_sra_sat: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && op_ref == 3'b011 && sc >= N) |-> (data_o == {N{d_ref[N-1]}}));

   a_r4_rot_keeps_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && op_ref[2:1] == 2'b10) |-> ($countones(data_o) == $countones(d_ref)));

   // R9: output held at zero while reset is asserted
   always @(negedge clk) begin
      if (REG_OUT && rst_n === 1'b0) begin
         a_r9_reset_clear: assert (data_o == '0);
      end
   end

endmodule

bind shf_unit shf_unit_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/shf_unit_tb_top.sv
module shf_unit_tb_top;

   localparam int NB = 32;
   localparam int CB = $clog2(NB) + 2;
   localparam int NS = 4;
   localparam int CS = $clog2(NS) + 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NB-1:0] d32 = '0, q32;
   logic [2:0]    op32 = '0;
   logic [CB-1:0] c32 = '0;
   logic [NS-1:0] d4 = '0, q4;
   logic [2:0]    op4 = '0;
   logic [CS-1:0] c4 = '0;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   shf_unit #(.N(NB)) dut_i (
      .clk(clk), .rst_n(rst_n), .data_i(d32), .op_i(op32), .cnt_i(c32), .data_o(q32));

   shf_unit #(.N(NS)) dut4_i (
      .clk(clk), .rst_n(rst_n), .data_i(d4), .op_i(op4), .cnt_i(c4), .data_o(q4));

   function automatic logic [31:0] model(logic [31:0] d, int op, int c, int w);
      int o = op;
      int m = c;
      logic [31:0] mask, r;
      logic f;
      if (op >= 6) return d;
      if (c < 0) begin o = op ^ 1; m = -c; end
      mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
      r = d & mask;
      f = (o == 2) ? d[0] : (o == 3) ? d[w-1] : 1'b0;
      if (o >= 4) m = m % w;
      for (int k = 0; k < m && k < w; k++) begin
         logic top, bot;
         top = r[w-1];
         bot = r[0];
         case (o)
            0, 2:    r = (r << 1) | {31'd0, f};
            1, 3:    r = (r >> 1) | ({31'd0, f} << (w - 1));
            4:       r = (r << 1) | {31'd0, top};
            default: r = (r >> 1) | ({31'd0, bot} << (w - 1));
         endcase
         r = r & mask;
      end
      return r;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic run32(string req, logic [NB-1:0] d, int op, int c);
      @(negedge clk);
      d32 = d; op32 = 3'(op); c32 = CB'(c);
      @(negedge clk);
      check(req, q32, model(d, op, c, NB));
   endtask

   task automatic run4(string req, logic [NS-1:0] d, int op, int c, logic [NS-1:0] exp);
      @(negedge clk);
      d4 = d; op4 = 3'(op); c4 = CS'(c);
      @(negedge clk);
      check(req, {28'd0, q4}, {28'd0, exp});
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      d32 = 32'hDEAD_BEEF; op32 = 3'd4; c32 = 7'd3; d4 = 4'hF;
      repeat (3) @(negedge clk);
      check("R9 reset 32", q32, '0);
      check("R9 reset 4", {28'd0, q4}, '0);
      rst_n = 1'b1;

      // R6 directed 4-bit cases
      run4("R6 sll1", 4'b1100, 0, 1, 4'b1000);
      run4("R6 srl2", 4'b1100, 1, 2, 4'b0011);
      run4("R6 sla1", 4'b1100, 2, 1, 4'b1000);
      run4("R6 sra2", 4'b1100, 3, 2, 4'b1111);
      run4("R6 rol1", 4'b1100, 4, 1, 4'b1001);
      run4("R6 ror2", 4'b1100, 5, 2, 4'b0011);
      run4("R6 R5 ror-1", 4'b1100, 5, -1, 4'b1001);
      run4("R2 sla fill one", 4'b0011, 2, 2, 4'b1111);
      run4("R3 sra sat", 4'b1000, 3, 7, 4'b1111);
      run4("R5 sla-8 sat msb", 4'b0110, 2, -8, 4'b0000);

      // 32-bit corner cases
      run32("R1 sll by N", 32'hFFFF_FFFF, 0, 32);
      run32("R1 srl by -63", 32'h8000_0001, 0, -63);
      run32("R2 sla sat", 32'h0000_0001, 2, 40);
      run32("R3 sra -64", 32'h8000_0000, 2, -64);
      run32("R4 rol mod N", 32'h1234_5678, 4, 33);
      run32("R4 ror 31", 32'h8000_0001, 5, 31);
      run32("R5 rol -5", 32'hCAFE_F00D, 4, -5);
      run32("R5 srl -3", 32'hCAFE_F00D, 1, -3);
      run32("R7 zero count", 32'hA5A5_1234, 3, 0);
      run32("R8 op6", 32'h0BAD_CAFE, 6, 17);
      run32("R8 op7", 32'h0BAD_CAFE, 7, -9);

      for (int i = 0; i < 3000; i++) begin
         int op, c;
         op = int'($urandom_range(7, 0));
         c  = int'($urandom_range(127, 0)) - 64;
         run32("R1..R8 random", $urandom, op, c);
      end
      for (int i = 0; i < 400; i++) begin
         int op, c;
         logic [NS-1:0] d;
         op = int'($urandom_range(7, 0));
         c  = int'($urandom_range(15, 0)) - 8;
         d  = NS'($urandom);
         run4("R4 R5 random 4-bit", d, op, c, NS'(model({28'd0, d}, op, c, NS)));
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (50000) @(posedge clk);
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule